// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, frame by frame, whether the frame is for this station. It watches the first six bytes of each frame, the destination address, and compares them against a programmed station address. It also compares them against the all-ones broadcast address. Failing both, it can consult a 64-bin multicast hash table indexed by a reflected CRC-32 of the address. The result is a single-cycle verdict pulse that a downstream buffer uses to keep or drop the frame. Frame storage, DMA and the frame check sequence belong to other blocks.

Configuration is written through a small register port with eight select codes. One mode register carries the receive enable, promiscuous and hash enable bits. Three 16-bit registers hold the station address and four 16-bit registers hold the hash table. The filter takes a snapshot of the whole configuration on every start-of-frame beat, so software may reprogram it while a frame is passing without disturbing that frame's verdict.

Top module: `rx_dest_filter`

## Requirements
- R1: With mode bit 0 (receive enable, select code 0) clear, every frame gets a reject verdict, whatever its address and whatever the other mode bits are.
- R2: With receive enable set and mode bit 6 (promiscuous) set, every frame of at least six bytes is accepted without any address comparison.
- R3: Select codes 1, 2 and 3 hold the station address. Code 1 carries destination byte 0 in bits 15:8 and byte 1 in bits 7:0, code 2 carries bytes 2 and 3, and code 3 carries bytes 4 and 5. A destination equal to all six bytes is accepted, even when the hash table would reject it.
- R4: A destination that differs from the station address in any single byte does not pass the station check.
- R5: A destination of FF:FF:FF:FF:FF:FF is accepted whenever receive enable is set, even when the hash table would reject it.
- R6: When the station and broadcast checks both fail and mode bit 11 (hash enable) is set, the index is bits 31:26 of a CRC-32 over the six destination bytes. The CRC starts at all ones, uses the reflected polynomial 0xEDB88320, takes each byte least significant bit first and gets no final inversion. Index bits 5:4 pick table word N, which is written at select code 7-N. Index bits 3:0 pick the bit within that word. A 1 accepts the frame and a 0 rejects it.
- R7: When the station and broadcast checks both fail and hash enable is clear, the frame is rejected, whatever the table holds.
- R8: Each frame produces exactly one verdict: res_valid is high for one cycle, the cycle after the beat that carries the sixth byte. Bytes after the sixth produce nothing further. res_valid is low after reset.
- R9: A frame whose end-of-frame beat comes before its sixth byte is rejected. Its verdict appears the cycle after that end beat. This includes a one-byte frame whose start and end flags share a beat.
- R10: Each frame uses the configuration as it stood before its start-of-frame beat. Writes made during the frame take effect from the next frame.
- R11: Cycles with in_valid low change nothing. A start-of-frame beat in the middle of an address restarts address capture from byte 0 and gives no verdict for the abandoned frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1-3 station address, 4-7 hash words 3..0 |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Receive byte valid |
| in_sof | input | 1 | Beat carries the first byte of a frame |
| in_eof | input | 1 | Beat carries the last byte of a frame |
| in_data | input | 8 | Receive byte |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Verdict: 1 keep frame, 0 drop frame |

## Verification
The hash path is the hard part to reach. Only particular addresses land on a given one of the 64 table bits, and the path is consulted only after the station and broadcast checks fail. The bench therefore computes the CRC index itself, bit-serially, and searches a multicast address family for one address that lands on each of the 64 bins. For each bin it programs a table with only that bit set and expects an accept. It then programs the complement and expects a reject. Configuration writes issued between the address bytes of an ongoing frame check that the start-of-frame snapshot holds.

// File: rtl/dfl_pkg.sv
`timescale 1ns/1ps
package dfl_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  // positions of the mode bits inside the mode register
  localparam int MODE_EN_BIT      = 0;
  localparam int MODE_PROMISC_BIT = 6;
  localparam int MODE_HASH_BIT    = 11;

  typedef struct packed {
    logic hash_en;
    logic promisc;
    logic enable;
  } filt_mode_t;

  // one byte of the reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc_le_step(input logic [31:0] crc_in,
                                              input logic [7:0]  octet);
    logic [31:0] c;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ octet[b]) c = (c >> 1) ^ CRC_POLY_REFL;
      else                 c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/dfl_cfg_regs.sv
`timescale 1ns/1ps
module dfl_cfg_regs
  import dfl_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int STA_REGS   = 3,
  parameter int HASH_WORDS = 4,
  parameter int SEL_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [REG_W-1:0]            wdata_i,
  input  logic                        sof_beat_i,
  output filt_mode_t                  mode_o,
  output logic [STA_REGS*REG_W-1:0]   station_o,
  output logic [HASH_WORDS*REG_W-1:0] table_o
);

  localparam int STA_W = STA_REGS * REG_W;
  localparam int TBL_W = HASH_WORDS * REG_W;
  localparam int TBL_SEL0 = STA_REGS + 1;

  filt_mode_t        mode_live, mode_snap;
  logic [STA_W-1:0]  sta_live,  sta_snap;
  logic [TBL_W-1:0]  tbl_live,  tbl_snap;

  // live registers written from the configuration port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_live <= '0;
      sta_live  <= '0;
      tbl_live  <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_W'(0)) begin
        mode_live.enable  <= wdata_i[MODE_EN_BIT];
        mode_live.promisc <= wdata_i[MODE_PROMISC_BIT];
        mode_live.hash_en <= wdata_i[MODE_HASH_BIT];
      end
      // station register s holds destination bytes 2s and 2s+1, byte 0 topmost
      for (int s = 0; s < STA_REGS; s++) begin
        if (sel_i == SEL_W'(1 + s))
          sta_live[(STA_REGS-1-s)*REG_W +: REG_W] <= wdata_i;
      end
      // table words sit in reverse: highest word at the lowest select code
      for (int w = 0; w < HASH_WORDS; w++) begin
        if (sel_i == SEL_W'(TBL_SEL0 + (HASH_WORDS - 1 - w)))
          tbl_live[w*REG_W +: REG_W] <= wdata_i;
      end
    end
  end

  // snapshot taken on every start-of-frame beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_snap <= '0;
      sta_snap  <= '0;
      tbl_snap  <= '0;
    end else if (sof_beat_i) begin
      mode_snap <= mode_live;
      sta_snap  <= sta_live;
      tbl_snap  <= tbl_live;
    end
  end

  // the start beat itself already sees the state it is about to freeze
  assign mode_o    = sof_beat_i ? mode_live : mode_snap;
  assign station_o = sof_beat_i ? sta_live  : sta_snap;
  assign table_o   = sof_beat_i ? tbl_live  : tbl_snap;

  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_beat_i |=> $stable(mode_snap) && $stable(sta_snap) && $stable(tbl_snap)); // R10

endmodule

// File: rtl/dfl_frame_track.sv
`timescale 1ns/1ps
module dfl_frame_track #(
  parameter int ADDR_BYTES = 6,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic [DATA_W-1:0]            in_data,
  output logic                         sof_beat_o,
  output logic                         take_o,
  output logic                         full_evt_o,
  output logic                         short_evt_o,
  output logic [ADDR_BYTES*DATA_W-1:0] dest_o
);

  localparam int POS_W = $clog2(ADDR_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic               active_q;
  logic [POS_W-1:0]   pos_q;
  logic [POS_W-1:0]   pos;
  logic               at_last;
  logic [DATA_W-1:0]  held_q [ADDR_BYTES];

  assign sof_beat_o  = in_valid && in_sof;
  assign pos         = in_sof ? '0 : pos_q;
  assign take_o      = in_valid && (in_sof || active_q);
  assign at_last     = (pos == LAST_POS);
  assign full_evt_o  = take_o && at_last;
  assign short_evt_o = take_o && in_eof && !at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      for (int i = 0; i < ADDR_BYTES; i++) held_q[i] <= '0;
    end else if (take_o) begin
      held_q[pos] <= in_data;
      if (at_last || in_eof) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        active_q <= 1'b1;
        pos_q    <= pos + POS_W'(1);
      end
    end
  end

  // address with the byte on the bus merged in, byte 0 in the top bits
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_dest
    assign dest_o[(ADDR_BYTES-1-i)*DATA_W +: DATA_W] =
      (take_o && pos == POS_W'(i)) ? in_data : held_q[i];
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (pos_q != '0) && (pos_q <= LAST_POS)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q) && $stable(active_q)); // R11

endmodule

// File: rtl/dfl_crc_acc.sv
`timescale 1ns/1ps
module dfl_crc_acc
  import dfl_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_beat_i,
  input  logic             take_i,
  input  logic [7:0]       in_data,
  output logic [IDX_W-1:0] hash_idx_o
);

  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_next;

  assign crc_base   = sof_beat_i ? CRC_SEED : crc_q;
  assign crc_next   = crc_le_step(crc_base, in_data);
  assign hash_idx_o = crc_next[31 -: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (take_i) crc_q <= crc_next;
  end

endmodule

// File: rtl/dfl_decide.sv
`timescale 1ns/1ps
module dfl_decide
  import dfl_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int TBL_W  = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  filt_mode_t        mode_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic [ADDR_W-1:0] dest_i,
  input  logic [TBL_W-1:0]  table_i,
  input  logic [IDX_W-1:0]  hash_idx_i,
  input  logic              full_evt_i,
  input  logic              short_evt_i,
  output logic              res_valid_o,
  output logic              res_accept_o
);

  logic station_hit, bcast_hit, hash_hit, verdict;

  // table flattened word-major: word idx[5:4], bit idx[3:0]
  function automatic logic table_pick(input logic [TBL_W-1:0] tbl,
                                      input logic [IDX_W-1:0] idx);
    return tbl[idx];
  endfunction

  always_comb begin
    station_hit = (dest_i == station_i);
    bcast_hit   = &dest_i;
    hash_hit    = table_pick(table_i, hash_idx_i);
    if (!mode_i.enable)                verdict = 1'b0;
    else if (mode_i.promisc)           verdict = 1'b1;
    else if (station_hit || bcast_hit) verdict = 1'b1;
    else                               verdict = mode_i.hash_en && hash_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o  <= 1'b0;
      res_accept_o <= 1'b0;
    end else begin
      res_valid_o  <= full_evt_i || short_evt_i;
      res_accept_o <= full_evt_i && verdict;
    end
  end

  AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !$past(mode_i.enable) |-> !res_accept_o); // R1

  AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(full_evt_i && mode_i.enable && mode_i.promisc) |-> res_accept_o); // R2

  AST_STATION_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(full_evt_i && mode_i.enable && station_hit) |-> res_accept_o); // R3

  AST_BCAST_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(full_evt_i && mode_i.enable && bcast_hit) |-> res_accept_o); // R5

  AST_HASH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(!mode_i.promisc && !mode_i.hash_en && !station_hit && !bcast_hit)
    |-> !res_accept_o); // R7

  AST_SHORT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(short_evt_i) |-> !res_accept_o); // R9

endmodule

// File: rtl/rx_dest_filter.sv
`timescale 1ns/1ps
module rx_dest_filter
  import dfl_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int REG_W      = 16,
  parameter int HASH_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  output logic       res_valid,
  output logic       res_accept
);

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = ADDR_BYTES * DATA_W;
  localparam int STA_REGS = ADDR_W / REG_W;
  localparam int TBL_W    = HASH_WORDS * REG_W;
  localparam int IDX_W    = $clog2(TBL_W);
  localparam int SEL_W    = $clog2(1 + STA_REGS + HASH_WORDS);

  filt_mode_t        mode;
  logic [ADDR_W-1:0] station;
  logic [TBL_W-1:0]  hash_tbl;
  logic [ADDR_W-1:0] dest;
  logic [IDX_W-1:0]  hash_idx;
  logic              sof_beat, take, full_evt, short_evt;

  dfl_cfg_regs #(
    .REG_W(REG_W), .STA_REGS(STA_REGS), .HASH_WORDS(HASH_WORDS), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel[SEL_W-1:0]),
    .wdata_i(cfg_wdata[REG_W-1:0]), .sof_beat_i(sof_beat),
    .mode_o(mode), .station_o(station), .table_o(hash_tbl)
  );

  dfl_frame_track #(
    .ADDR_BYTES(ADDR_BYTES), .DATA_W(DATA_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .sof_beat_o(sof_beat), .take_o(take),
    .full_evt_o(full_evt), .short_evt_o(short_evt), .dest_o(dest)
  );

  dfl_crc_acc #(
    .IDX_W(IDX_W)
  ) u_crc (
    .clk(clk), .rst_n(rst_n), .sof_beat_i(sof_beat), .take_i(take),
    .in_data(in_data), .hash_idx_o(hash_idx)
  );

  dfl_decide #(
    .ADDR_W(ADDR_W), .TBL_W(TBL_W), .IDX_W(IDX_W)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .station_i(station), .dest_i(dest),
    .table_i(hash_tbl), .hash_idx_i(hash_idx), .full_evt_i(full_evt),
    .short_evt_i(short_evt), .res_valid_o(res_valid), .res_accept_o(res_accept)
  );

endmodule

// File: tb/rx_dest_filter_bench.sv
`timescale 1ns/1ps
module rx_dest_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        res_valid, res_accept;

  int total = 0, bad = 0, cyc = 0, n_res = 0, res_cyc = 0;
  logic last_acc = 1'b0;
  logic done = 1'b0;

  logic [15:0] cur_mode = '0;
  logic [47:0] cur_sta  = '0;
  logic [63:0] cur_tbl  = '0;

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STA   = 48'h0211_2233_4455;

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .res_valid(res_valid),
    .res_accept(res_accept)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (res_valid) begin
    n_res++; last_acc = res_accept; res_cyc = cyc;
  end

  // bit-serial reflected CRC, bits taken in wire order
  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = r[0] ^ da[40 - 8*(i/8) + (i%8)];
      r = {1'b0, r[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return r[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] da, input int nb);
    if (nb < 6 || !cur_mode[0]) return 1'b0;
    if (cur_mode[6]) return 1'b1;
    if (da == cur_sta || da == BCAST) return 1'b1;
    if (cur_mode[11]) return cur_tbl[ref_idx(da)];
    return 1'b0;
  endfunction

  function automatic logic [7:0] fbyte(input logic [47:0] da, input int k);
    if (k < 6) return da[47-8*k -: 8];
    return 8'(8'h3C + k);
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] v);
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic [15:0] m);
    wr(3'd0, m); cur_mode = m;
  endtask

  task automatic set_sta(input logic [47:0] a);
    wr(3'd1, a[47:32]); wr(3'd2, a[31:16]); wr(3'd3, a[15:0]); cur_sta = a;
  endtask

  task automatic set_tbl(input logic [63:0] t);
    for (int w = 0; w < 4; w++) wr(3'(7 - w), t[w*16 +: 16]);
    cur_tbl = t;
  endtask

  task automatic beat(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk); in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  task automatic send(input logic [47:0] da, input int nb, input int gap, output int dc);
    dc = 0;
    for (int k = 0; k < nb; k++) begin
      beat(fbyte(da, k), k == 0, k == nb - 1);
      if (k == ((nb < 6) ? nb - 1 : 5)) dc = cyc;
      if (gap > 0 && k < nb - 1) quiet(gap);
    end
    quiet(3);
  endtask

  task automatic frame(input string tag, input logic [47:0] da, input int nb, input int gap);
    int n0, dc;
    logic exp;
    exp = ref_accept(da, nb);
    n0 = n_res;
    send(da, nb, gap, dc);
    check({tag, " verdict count"}, n_res - n0, 1);
    check({tag, " accept"}, last_acc, exp);
    check({tag, " verdict cycle"}, res_cyc, dc + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0, dc;
    logic [47:0] da;
    repeat (3) @(negedge clk);
    check("R8 reset res_valid low", res_valid, 0);
    rst_n = 1'b1;
    quiet(2);
    check("R8 idle after reset", res_valid, 0);

    set_sta(STA);
    set_tbl(64'h0);

    // R1: receive disabled
    set_mode(16'h0000);
    frame("R1 station while off", STA, 8, 0);
    frame("R1 broadcast while off", BCAST, 8, 0);
    set_mode(16'h0840);
    frame("R1 promisc+hash while off", 48'h0102_0304_0506, 8, 0);

    // R3 / R4: station match and single-byte mismatches
    set_mode(16'h0001);
    frame("R3 station exact", STA, 8, 0);
    for (int p = 0; p < 6; p++) begin
      da = STA ^ (48'h01 << (8*(5-p)));
      frame($sformatf("R4 mismatch byte %0d", p), da, 8, 0);
    end

    // R5 broadcast; R7 hash disabled
    frame("R5 broadcast", BCAST, 8, 0);
    set_tbl(64'hFFFF_FFFF_FFFF_FFFF);
    frame("R7 hash off full table", 48'h0100_5E00_0001, 8, 0);
    frame("R7 hash off unicast", 48'h0A0B_0C0D_0E0F, 8, 0);

    // R3 / R5 priority over an empty table with hash on
    set_tbl(64'h0);
    set_mode(16'h0801);
    frame("R3 station beats hash", STA, 8, 0);
    frame("R5 broadcast beats hash", BCAST, 8, 0);

    // R6: every hash bin, set alone then cleared alone
    for (int t = 0; t < 64; t++) begin
      logic found = 1'b0;
      da = '0;
      for (int a = 0; a < 65536 && !found; a++) begin
        logic [47:0] c;
        c = {32'h0100_5E7F, 16'(a)};
        if (ref_idx(c) == 6'(t)) begin da = c; found = 1'b1; end
      end
      check($sformatf("R6 bench found address for bin %0d", t), found, 1);
      set_tbl(64'h1 << t);
      frame($sformatf("R6 bin %0d set", t), da, 8, 0);
      set_tbl(~(64'h1 << t));
      frame($sformatf("R6 bin %0d clear", t), da, 8, 0);
    end

    // R2: promiscuous
    set_tbl(64'h0);
    set_mode(16'h0041);
    frame("R2 promisc unicast", 48'h0A0B_0C0D_0E0F, 8, 0);
    frame("R2 promisc multicast", 48'h3300_0000_0001, 6, 0);

    // R9: short frames rejected even in promiscuous mode
    for (int nb = 1; nb < 6; nb++)
      frame($sformatf("R9 short %0d bytes", nb), STA, nb, 0);

    // R8: long frame, one verdict only
    set_mode(16'h0001);
    frame("R8 long frame", STA, 40, 0);
    frame("R8 exactly six bytes", STA, 6, 0);

    // R11: gaps and restart
    frame("R11 gapped bytes", STA, 8, 2);
    n0 = n_res;
    beat(8'h77, 1'b1, 1'b0); beat(8'h66, 1'b0, 1'b0); quiet(2);
    beat(8'h55, 1'b0, 1'b0);
    send(STA, 8, 0, dc);
    check("R11 restart verdict count", n_res - n0, 1);
    check("R11 restart accept", last_acc, 1);
    check("R11 restart verdict cycle", res_cyc, dc + 1);

    // R10: mid-frame write does not affect current frame
    da = 48'h0A0B_0C0D_0E0F;
    n0 = n_res;
    for (int k = 0; k < 3; k++) beat(fbyte(da, k), k == 0, 1'b0);
    set_mode(16'h0041);
    for (int k = 3; k < 6; k++) beat(fbyte(da, k), 1'b0, k == 5);
    quiet(3);
    check("R10 frame keeps old mode count", n_res - n0, 1);
    check("R10 frame keeps old mode reject", last_acc, 0);
    frame("R10 next frame sees promisc", da, 8, 0);
    n0 = n_res;
    for (int k = 0; k < 2; k++) beat(fbyte(da, k), k == 0, 1'b0);
    set_mode(16'h0000);
    set_sta(da);
    for (int k = 2; k < 6; k++) beat(fbyte(da, k), 1'b0, k == 5);
    quiet(3);
    check("R10 frame keeps promisc count", n_res - n0, 1);
    check("R10 frame keeps promisc accept", last_acc, 1);
    frame("R10 next frame sees disable", da, 8, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule